// File: doc/BRIEF.md
# Receive Frame Qualifier for a Multidrop Serial Link

This block sits behind a UART receive shift engine and decides what happens to each finished frame. When the shift engine pulses its frame-done strobe, the qualifier looks at the eight data bits, the ninth bit and the sampled stop bit. It also looks at the active serial mode and at the receiver and multiprocessor enables. From these it decides whether to raise the receive-complete pulse and load the receive byte and the ninth-bit register. Independently of that decision, it records a framing error whenever the stop bit was sampled low.

In the 9-bit modes with multiprocessor filtering on, only address frames can get through, and only when their byte matches this station. A frame is an address frame when its ninth bit is 1. Matching is per bit: wherever the care mask holds a 0, the station address bit is a don't-care. One station can therefore answer to a small family of addresses. A second, broadcast address is formed as the bitwise OR of the station address and the mask, and a match on it is accepted in the same way. Software clears the sticky framing error flag with a one-cycle clear strobe.

All results are registered and appear one clock after the frame-done strobe.

Top module: `rx_frame_qualifier`

## Requirements
- R1: After synchronous reset, `ri_set`, `rx_byte`, `rb8` and `fe` are all 0.
- R2: A `frame_done` strobe while `ren` is 0 has no effect: no `ri_set`, no change to `rx_byte`, `rb8` or `fe`.
- R3: With `ren` 1 and `sm2` 0, every `frame_done` gives `ri_set` high for exactly the next cycle, and `rx_byte` takes the frame's data byte in that same cycle.
- R4: On an accepted frame, `rb8` loads `rx_bit9` in modes 2 and 3 (`mode` = 2'b10 or 2'b11) and loads `rx_stop` in mode 1 (`mode` = 2'b01). In mode 0 (`mode` = 2'b00) it keeps its value.
- R5: In modes 1, 2 and 3, a frame taken in with `ren` 1 and `rx_stop` 0 sets `fe` in the following cycle, whether or not the frame is accepted. Mode 0 frames never set `fe`.
- R6: `fe` stays 1 through later good frames until a cycle with `fe_clr` 1 clears it. When a framing error and `fe_clr` arrive in the same cycle, `fe` ends up 1.
- R7: In modes 2 and 3 with `sm2` 1, a frame with `rx_bit9` 1 is accepted when every data bit whose `addr_mask` bit is 1 equals the matching `own_addr` bit.
- R8: In modes 2 and 3 with `sm2` 1, a frame with `rx_bit9` 1 is also accepted when every data bit whose `addr_mask` bit is 1 equals the matching bit of (`own_addr` OR `addr_mask`).
- R9: In modes 2 and 3 with `sm2` 1, a frame with `rx_bit9` 0 is dropped: no `ri_set`, and `rx_byte` and `rb8` keep their values.
- R10: In mode 1 with `sm2` 1, a frame is accepted only when `rx_stop` is 1.
- R11: When `addr_mask` is all zeros, every address frame is accepted in modes 2 and 3 with `sm2` 1.
- R12: An address frame that matches neither address gives no `ri_set`, and `rx_byte` and `rb8` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe: a frame has been fully shifted in |
| rx_data | input | DATA_W | Received data byte |
| rx_bit9 | input | 1 | Received ninth bit (address marker in 9-bit modes) |
| rx_stop | input | 1 | Sampled stop bit |
| mode | input | 2 | Serial mode: 0 shift, 1 8-bit UART, 2 and 3 9-bit UART |
| sm2 | input | 1 | Multiprocessor filter enable |
| ren | input | 1 | Receiver enable |
| own_addr | input | DATA_W | Station address |
| addr_mask | input | DATA_W | Care mask; 0 bits are don't-care |
| fe_clr | input | 1 | Software clear strobe for the framing error flag |
| ri_set | output | 1 | Receive-complete set pulse |
| rx_byte | output | DATA_W | Last accepted data byte |
| rb8 | output | 1 | Last accepted ninth bit (stop bit in mode 1) |
| fe | output | 1 | Sticky framing error flag |

## Verification
The bench sweeps every byte value against several address and mask setups in 9-bit filtered mode. These include two overlapping don't-care masks and an all-zero mask. A design that compared bits under mask 0, or left out the broadcast term, would accept or reject the wrong bytes. Rejected and dropped frames are followed by reads of `rx_byte` and `rb8`, which catches a design that loads the buffer without raising the pulse. The framing flag is driven through a later good frame, through a clear, and through a clear that collides with a new error. This exposes a flag that self-clears or lets the clear win. Mode 1 with a low stop bit, mode 0 with its ninth-bit register held, and frames sent while the receiver is disabled cover the remaining mode-dependent paths.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'd0,
        MODE_UART8  = 2'd1,
        MODE_UART9F = 2'd2,
        MODE_UART9V = 2'd3
    } rx_mode_e;

    typedef struct packed {
        logic take;      // frame accepted: pulse and buffer load
        logic err;       // framing error seen
        logic rb8_load;  // ninth-bit register updates
        logic rb8_val;   // value loaded into it
    } rx_verdict_t;

    function automatic logic nine_bit_mode(input rx_mode_e m);
        return m == MODE_UART9F || m == MODE_UART9V;
    endfunction

    function automatic logic has_stop_bit(input rx_mode_e m);
        return m != MODE_SHIFT;
    endfunction

endpackage

// File: rtl/rxq_addr_match.sv
module rxq_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] station_addr,
    input  logic [W-1:0] care_mask,
    output logic         own_hit,
    output logic         bcast_hit
);
    logic [W-1:0] bcast_addr;
    logic [W-1:0] own_bits;
    logic [W-1:0] bc_bits;

    assign bcast_addr = station_addr | care_mask;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign own_bits[i] = !care_mask[i] || (rx_byte[i] == station_addr[i]);
        assign bc_bits[i]  = !care_mask[i] || (rx_byte[i] == bcast_addr[i]);
    end

    assign own_hit   = &own_bits;
    assign bcast_hit = &bc_bits;
endmodule

// File: rtl/rxq_decide.sv
module rxq_decide
    import rxq_pkg::*;
(
    input  logic        strobe,
    input  logic        ren,
    input  rx_mode_e    mode,
    input  logic        sm2,
    input  logic        bit9,
    input  logic        stop_bit,
    input  logic        addr_hit,
    output rx_verdict_t verdict
);
    logic live;
    logic pass;

    assign live = strobe && ren;

    always_comb begin
        unique case (mode)
            MODE_SHIFT: pass = 1'b1;
            MODE_UART8: pass = !sm2 || stop_bit;
            default:    pass = !sm2 || (bit9 && addr_hit);
        endcase
    end

    always_comb begin
        verdict          = '0;
        verdict.take     = live && pass;
        verdict.err      = live && has_stop_bit(mode) && !stop_bit;
        verdict.rb8_load = live && pass && mode != MODE_SHIFT;
        verdict.rb8_val  = nine_bit_mode(mode) ? bit9 : stop_bit;
    end
endmodule

// File: rtl/rxq_err_flag.sv
module rxq_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/rx_frame_qualifier.sv
module rx_frame_qualifier
    import rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              rx_stop,
    input  logic [1:0]        mode,
    input  logic              sm2,
    input  logic              ren,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              fe_clr,
    output logic              ri_set,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rb8,
    output logic              fe
);
    logic        own_hit;
    logic        bcast_hit;
    rx_verdict_t verdict;

    rxq_addr_match #(.W(DATA_W)) i_match (
        .rx_byte      (rx_data),
        .station_addr (own_addr),
        .care_mask    (addr_mask),
        .own_hit      (own_hit),
        .bcast_hit    (bcast_hit)
    );

    rxq_decide i_decide (
        .strobe   (frame_done),
        .ren      (ren),
        .mode     (rx_mode_e'(mode)),
        .sm2      (sm2),
        .bit9     (rx_bit9),
        .stop_bit (rx_stop),
        .addr_hit (own_hit || bcast_hit),
        .verdict  (verdict)
    );

    rxq_err_flag i_fe (
        .clk    (clk),
        .rst    (rst),
        .set_i  (verdict.err),
        .clr_i  (fe_clr),
        .flag_o (fe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ri_set  <= 1'b0;
            rx_byte <= '0;
            rb8     <= 1'b0;
        end else begin
            ri_set <= verdict.take;
            if (verdict.take)
                rx_byte <= rx_data;
            if (verdict.rb8_load)
                rb8 <= verdict.rb8_val;
        end
    end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_done,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              rx_stop,
    input logic [1:0]        mode,
    input logic              sm2,
    input logic              ren,
    input logic [DATA_W-1:0] own_addr,
    input logic [DATA_W-1:0] addr_mask,
    input logic              fe_clr,
    input logic              ri_set,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rb8,
    input logic              fe
);
    // R2
    ri_needs_ren_chk: assert property (@(posedge clk) disable iff (rst)
        ri_set |-> $past(frame_done && ren));

    // R3
    byte_follows_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ri_set |-> rx_byte == $past(rx_data));

    // R5
    fe_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ren && mode != 2'd0 && !rx_stop) |=> fe);

    // R6
    fe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fe && !fe_clr) |=> fe);

    // R9
    data_frame_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ren && sm2 && mode[1] && !rx_bit9) |=> (!ri_set && $stable(rx_byte) && $stable(rb8)));

    // R10
    mode1_stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ren && sm2 && mode == 2'd1 && !rx_stop) |=> !ri_set);

    // R11
    open_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ren && sm2 && mode[1] && rx_bit9 && addr_mask == '0) |=> ri_set);
endmodule

bind rx_frame_qualifier rxq_checker #(.DATA_W(DATA_W)) i_rxq_checker (.*);

// File: tb/test_rx_frame_qualifier.sv
module test_rx_frame_qualifier;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_bit9 = 1'b0;
    logic       rx_stop = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       sm2 = 1'b0;
    logic       ren = 1'b0;
    logic [7:0] own_addr = '0;
    logic [7:0] addr_mask = '0;
    logic       fe_clr = 1'b0;
    logic       ri_set;
    logic [7:0] rx_byte;
    logic       rb8;
    logic       fe;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    logic [7:0] exp_byte = '0;
    logic       exp_rb8  = 1'b0;
    logic       exp_fe   = 1'b0;

    always #2 clk = ~clk;

    rx_frame_qualifier i_rx_frame_qualifier (
        .clk(clk), .rst(rst), .frame_done(frame_done), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_stop(rx_stop), .mode(mode), .sm2(sm2), .ren(ren),
        .own_addr(own_addr), .addr_mask(addr_mask), .fe_clr(fe_clr),
        .ri_set(ri_set), .rx_byte(rx_byte), .rb8(rb8), .fe(fe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bitwise masked comparison, one position at a time
    function automatic bit hits(input logic [7:0] d, input logic [7:0] a, input logic [7:0] m);
        for (int i = 0; i < 8; i++)
            if (m[i] && d[i] != a[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic send(input logic [7:0] d, input logic b9, input logic stp,
                        input logic [1:0] md, input logic s2, input logic en,
                        input logic clr, input string tag);
        bit own, bc, acc, err;
        own = hits(d, own_addr, addr_mask);
        bc  = hits(d, own_addr | addr_mask, addr_mask);
        case (md)
            2'd0:    acc = 1'b1;
            2'd1:    acc = !s2 || stp;
            default: acc = !s2 || (b9 && (own || bc));
        endcase
        acc = acc && en;
        err = en && md != 2'd0 && !stp;
        @(negedge clk);
        rx_data = d; rx_bit9 = b9; rx_stop = stp; mode = md; sm2 = s2; ren = en;
        fe_clr = clr; frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0; fe_clr = 1'b0;
        if (acc) begin
            exp_byte = d;
            if (md == 2'd1) exp_rb8 = stp;
            else if (md[1]) exp_rb8 = b9;
        end
        if (err) exp_fe = 1'b1;
        else if (clr) exp_fe = 1'b0;
        chk({tag, " ri"}, 32'(ri_set), 32'(acc));
        chk({tag, " byte"}, 32'(rx_byte), 32'(exp_byte));
        chk({tag, " rb8"}, 32'(rb8), 32'(exp_rb8));
        chk({tag, " fe"}, 32'(fe), 32'(exp_fe));
        @(negedge clk);
        chk({tag, " ri one cycle"}, 32'(ri_set), 32'd0);
    endtask

    task automatic sweep(input logic [7:0] a, input logic [7:0] m);
        own_addr = a; addr_mask = m;
        for (int d = 0; d < 256; d++) begin
            bit o, b;
            string t;
            o = hits(8'(d), a, m);
            b = hits(8'(d), a | m, m);
            if (m == 8'h00) t = "R11 open mask";
            else if (o) t = "R7 own match";
            else if (b) t = "R8 broadcast";
            else t = "R12 reject";
            send(8'(d), 1'b1, 1'b1, 2'd2 + 2'(d & 1), 1'b1, 1'b1, 1'b0, t);
        end
        for (int d = 0; d < 256; d += 37)
            send(8'(d), 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, "R9 data frame dropped");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ri", 32'(ri_set), 0);
        chk("R1 byte", 32'(rx_byte), 0);
        chk("R1 rb8", 32'(rb8), 0);
        chk("R1 fe", 32'(fe), 0);

        send(8'hA5, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, "R2 receiver off");
        send(8'h3C, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, "R3 mode1");
        send(8'hC3, 1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, "R3 mode3 bit9=0");
        send(8'h81, 1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0, "R4 mode2 bit9=1");
        send(8'h7E, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R4 mode0 rb8 held");
        send(8'h11, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, "R5 mode0 no fe");
        send(8'h22, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, "R5 mode1 low stop");
        send(8'h33, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, "R6 fe kept");
        send(8'h44, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, "R6 fe cleared");
        send(8'h55, 1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, "R6 set beats clear");
        send(8'h66, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, "R6 fe cleared again");
        send(8'h77, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, "R10 mode1 sm2 low stop");
        send(8'h88, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b1, "R10 mode1 sm2 good stop");

        sweep(8'hC0, 8'hFD);
        sweep(8'hC0, 8'hFE);
        sweep(8'h00, 8'h00);
        sweep(8'h5A, 8'h0F);
        sweep(8'h96, 8'hFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule